// File: doc/BRIEF.md
# Single-Cycle Load/Store RISC Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. Each cycle it does four things. It presents the program counter on an instruction read port and decodes the returned word. It reads two operands from a 32-entry register file and runs them through the ALU. It then retires the instruction, either by writing a register, by driving a store on the data port, or by redirecting the program counter. Instruction and data memories sit outside the core. Both are read combinationally within the same cycle, so the core never needs an address or a datapath resource twice per instruction.

The instruction set is a small load/store subset. It covers word load and store, four register-to-register arithmetic and logic operations, a signed set-if-less-than, a branch taken on register equality, and an absolute jump within the current 256 MiB region. Any other encoding is treated as a no-operation. Overflow never traps.

Top module: `sc_core`

## Requirements
- R1: While the synchronous active-high `rst` is sampled high at a clock edge, the program counter loads `RESET_PC` (default 0), and `imemAddr` always shows the program counter.
- R2: After any instruction that is neither a branch nor a jump, the program counter advances by exactly 4.
- R3: With opcode 0x00 in bits 31-26, funct (bits 5-0) 0x20 adds, 0x22 subtracts (rs minus rt), 0x24 ANDs and 0x25 ORs the registers named by bits 25-21 (rs) and 20-16 (rt). The result goes to the register named by bits 15-11 (rd). Results wrap modulo 2^32.
- R4: Funct 0x2A with opcode 0x00 writes 1 to rd when rs is less than rt as two's-complement numbers, and 0 otherwise.
- R5: Opcode 0x23 (load) drives `dmemAddr` = rs + sign-extended bits 15-0 with `dmemRe` high. It writes `dmemRdata` into the register named by bits 20-16 (rt).
- R6: Opcode 0x2B (store) drives the same address form, puts the rt register value on `dmemWdata` and raises `dmemWe` for that cycle. It writes no register, whatever bits 15-11 hold.
- R7: Opcode 0x04 (branch) compares rs and rt. When they are equal, the next program counter is PC+4 plus the sign-extended bits 15-0 shifted left by 2. Otherwise it is PC+4.
- R8: Opcode 0x02 (jump) sets the next program counter to bits 31-28 of PC+4, followed by bits 25-0 of the instruction and two zero bits.
- R9: Register 0 always reads as zero. Writes that name it, from either a load or an R-type instruction, are dropped.
- R10: `dmemWe` and `dmemRe` are never high together, and both stay low for everything except stores and loads. An unlisted opcode, or an opcode-0x00 word with an unlisted funct, changes no register and advances the program counter by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the program counter |
| imemAddr | output | 32 | Byte address of the instruction being executed |
| imemData | input | 32 | Instruction word at `imemAddr`, combinational |
| dmemAddr | output | 32 | Byte address for a load or store |
| dmemWdata | output | 32 | Store data |
| dmemWe | output | 1 | Store strobe, written at the next rising edge |
| dmemRe | output | 1 | Load strobe |
| dmemRdata | input | 32 | Load data for `dmemAddr`, combinational |

## Verification
The bench builds the core with its default `RESET_PC` of 0. This keeps every fetched address inside a 64-word program window. It indexes both memory models by address bits 7-2, so negative load and store offsets reach the top words of the data window. With the program counter kept low, the jump tests show the region bits staying at zero while the 26-bit target field replaces the rest. Every register a test relies on is first loaded from the data memory through loads. Its contents are then read back at the data port through stores. This makes stores the only view of the register file, and it covers signed compares, wrap-around, writes to register 0 and stray rd fields on stores.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;
  localparam int XLEN    = 32;
  localparam int REG_NUM = 32;
  localparam int REG_AW  = $clog2(REG_NUM);
  localparam int IMM_W   = 16;
  localparam int OPC_W   = 6;
  localparam int FN_W    = 6;
  localparam int JTGT_W  = 26;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h02;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;

  localparam logic [FN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_AND = 3'd0,
    ALU_OR  = 3'd1,
    ALU_ADD = 3'd2,
    ALU_SUB = 3'd3,
    ALU_SLT = 3'd4
  } aluOp_e;

  typedef struct packed {
    logic   regDst;
    logic   aluSrc;
    logic   memToReg;
    logic   regWrite;
    logic   memRead;
    logic   memWrite;
    logic   branch;
    logic   jump;
    aluOp_e aluOp;
  } ctrl_t;
endpackage

// File: rtl/sc_control.sv
`timescale 1ns/1ps
module sc_control
  import sc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output ctrl_t            ctrl
);

  always_comb begin
    ctrl       = '0;
    ctrl.aluOp = ALU_ADD;
    case (opcode)
      OPC_RTYPE: begin
        ctrl.regDst   = 1'b1;
        ctrl.regWrite = 1'b1;
        case (funct)
          FN_ADD:  ctrl.aluOp = ALU_ADD;
          FN_SUB:  ctrl.aluOp = ALU_SUB;
          FN_AND:  ctrl.aluOp = ALU_AND;
          FN_OR:   ctrl.aluOp = ALU_OR;
          FN_SLT:  ctrl.aluOp = ALU_SLT;
          default: ctrl.regWrite = 1'b0;
        endcase
      end
      OPC_LOAD: begin
        ctrl.aluSrc   = 1'b1;
        ctrl.memToReg = 1'b1;
        ctrl.regWrite = 1'b1;
        ctrl.memRead  = 1'b1;
      end
      OPC_STORE: begin
        ctrl.aluSrc   = 1'b1;
        ctrl.memWrite = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.aluOp  = ALU_SUB;
      end
      OPC_JUMP: ctrl.jump = 1'b1;
      default: ;
    endcase
  end

  AST_STORE_NO_REGWR: assert property (@(posedge clk) disable iff (rst)
    ctrl.memWrite |-> !ctrl.regWrite); // R6
  AST_MEM_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.memRead, ctrl.memWrite, ctrl.branch, ctrl.jump})); // R10
  AST_MEM_ONLY_LDST: assert property (@(posedge clk) disable iff (rst)
    (opcode != OPC_LOAD && opcode != OPC_STORE) |-> !(ctrl.memRead || ctrl.memWrite)); // R10

endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile #(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 32,
  localparam int ADDR_W = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rdAddrA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData
);

  logic [DATA_W-1:0] regVal [REG_CNT];

  for (genvar g = 0; g < REG_CNT; g++) begin : gEntry
    if (g == 0) begin : gZero
      assign regVal[g] = '0;
    end else begin : gStore
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (wrEn && wrAddr == ADDR_W'(g)) q <= wrData;
      end
      assign regVal[g] = q;
    end
  end

  assign rdDataA = regVal[rdAddrA];
  assign rdDataB = regVal[rdAddrB];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr != '0) |=> (regVal[$past(wrAddr)] == $past(wrData))); // R3

endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
  import sc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  aluOp_e            op,
  output logic [DATA_W-1:0] result,
  output logic              zero
);

  always_comb begin
    case (op)
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = opA - opB;
      ALU_SLT: result = {{(DATA_W-1){1'b0}}, ($signed(opA) < $signed(opB))};
      default: result = '0;
    endcase
  end

  assign zero = (result == '0);

endmodule

// File: rtl/sc_datapath.sv
`timescale 1ns/1ps
module sc_datapath
  import sc_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [JTGT_W-1:0] instrLow,
  output logic [XLEN-1:0]   pc,
  output logic [XLEN-1:0]   memAddr,
  output logic [XLEN-1:0]   memWdata,
  input  logic [XLEN-1:0]   memRdata
);

  localparam int REGION_W = XLEN - JTGT_W - 2;

  logic [XLEN-1:0]   pcQ, pcPlus4, branchTarget, jumpTarget, pcNext;
  logic [XLEN-1:0]   immExt, srcA, srcB, rtVal, aluY, wbData;
  logic [REG_AW-1:0] rsIdx, rtIdx, rdIdx, wrIdx;
  logic              aluZero;

  assign rsIdx  = instrLow[25:21];
  assign rtIdx  = instrLow[20:16];
  assign rdIdx  = instrLow[15:11];
  assign immExt = {{(XLEN-IMM_W){instrLow[IMM_W-1]}}, instrLow[IMM_W-1:0]};

  sc_regfile #(.DATA_W(XLEN), .REG_CNT(REG_NUM)) uRegs (
    .clk     (clk),
    .rst     (rst),
    .rdAddrA (rsIdx),
    .rdAddrB (rtIdx),
    .rdDataA (srcA),
    .rdDataB (rtVal),
    .wrEn    (ctrl.regWrite),
    .wrAddr  (wrIdx),
    .wrData  (wbData)
  );

  assign srcB  = ctrl.aluSrc ? immExt : rtVal;
  assign wrIdx = ctrl.regDst ? rdIdx : rtIdx;

  sc_alu #(.DATA_W(XLEN)) uAlu (
    .opA    (srcA),
    .opB    (srcB),
    .op     (ctrl.aluOp),
    .result (aluY),
    .zero   (aluZero)
  );

  assign wbData = ctrl.memToReg ? memRdata : aluY;

  assign pcPlus4      = pcQ + XLEN'(4);
  assign branchTarget = pcPlus4 + (immExt << 2);
  assign jumpTarget   = {pcPlus4[XLEN-1 -: REGION_W], instrLow, 2'b00};

  always_comb begin
    if (ctrl.jump)                    pcNext = jumpTarget;
    else if (ctrl.branch && aluZero)  pcNext = branchTarget;
    else                              pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pcQ <= RESET_PC;
    else     pcQ <= pcNext;
  end

  assign pc       = pcQ;
  assign memAddr  = aluY;
  assign memWdata = rtVal;

  AST_PC_RESET: assert property (@(posedge clk)
    rst |=> (pcQ == RESET_PC)); // R1
  AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    !(ctrl.jump || ctrl.branch) |=> (pcQ == $past(pcQ) + XLEN'(4))); // R2
  AST_BEQ_FALLTHROUGH: assert property (@(posedge clk) disable iff (rst)
    (ctrl.branch && srcA != rtVal) |=> (pcQ == $past(pcQ) + XLEN'(4))); // R7
  AST_BEQ_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    ctrl.branch |-> (aluZero == (srcA == rtVal))); // R7
  AST_JUMP_FIELD: assert property (@(posedge clk) disable iff (rst)
    ctrl.jump |=> (pcQ[JTGT_W+1:0] == {$past(instrLow), 2'b00})); // R8

endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core
  import sc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imemAddr,
  input  logic [31:0] imemData,
  output logic [31:0] dmemAddr,
  output logic [31:0] dmemWdata,
  output logic        dmemWe,
  output logic        dmemRe,
  input  logic [31:0] dmemRdata
);

  ctrl_t ctrl;

  sc_control uCtrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (imemData[31:26]),
    .funct  (imemData[5:0]),
    .ctrl   (ctrl)
  );

  sc_datapath #(.RESET_PC(RESET_PC)) uPath (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .instrLow (imemData[JTGT_W-1:0]),
    .pc       (imemAddr),
    .memAddr  (dmemAddr),
    .memWdata (dmemWdata),
    .memRdata (dmemRdata)
  );

  assign dmemWe = ctrl.memWrite;
  assign dmemRe = ctrl.memRead;

  AST_PORT_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(dmemWe && dmemRe)); // R10

endmodule

// File: tb/sim_sc_core.sv
`timescale 1ns/1ps
module sim_sc_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imemAddr, imemData, dmemAddr, dmemWdata, dmemRdata;
  logic        dmemWe, dmemRe;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  assign imemData  = imem[imemAddr[7:2]];
  assign dmemRdata = dmem[dmemAddr[7:2]];

  sc_core u0 (
    .clk       (clk),
    .rst       (rst),
    .imemAddr  (imemAddr),
    .imemData  (imemData),
    .dmemAddr  (dmemAddr),
    .dmemWdata (dmemWdata),
    .dmemWe    (dmemWe),
    .dmemRe    (dmemRe),
    .dmemRdata (dmemRdata)
  );

  function automatic logic [31:0] encR(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction

  function automatic logic [31:0] encI(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction

  function automatic logic [31:0] encJ(logic [25:0] tgt);
    return {6'h02, tgt};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'h0;
      dmem[i] = 32'h0;
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic expectStore(string tag, logic [31:0] addr, logic [31:0] data);
    check({tag, " store strobe"}, {31'd0, dmemWe}, 32'd1);
    check({tag, " store addr"}, dmemAddr, addr);
    check({tag, " store data"}, dmemWdata, data);
  endtask

  task automatic testReset();
    clearMem();
    doReset();
    check("R1 pc after reset", imemAddr, 32'h0);
    check("R10 no strobes on nop", {30'd0, dmemWe, dmemRe}, 32'd0);
    step(3);
    check("R2 pc after three nops", imemAddr, 32'd12);
    @(negedge clk);
    rst = 1'b1;
    step();
    check("R1 synchronous reset mid-run", imemAddr, 32'h0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic testArith();
    clearMem();
    dmem[0] = 32'd5;
    dmem[1] = 32'hFFFF_FFFD;
    dmem[3] = 32'h7FFF_FFFF;
    dmem[4] = 32'd1;
    imem[0]  = encI(6'h23, 0, 1, 16'h0000);
    imem[1]  = encI(6'h23, 0, 2, 16'h0004);
    imem[2]  = encR(1, 2, 3, 6'h20);
    imem[3]  = encI(6'h2B, 0, 3, 16'h0040);
    imem[4]  = encR(1, 2, 4, 6'h22);
    imem[5]  = encI(6'h2B, 0, 4, 16'h0040);
    imem[6]  = encR(1, 2, 5, 6'h24);
    imem[7]  = encI(6'h2B, 0, 5, 16'h0040);
    imem[8]  = encR(1, 2, 6, 6'h25);
    imem[9]  = encI(6'h2B, 0, 6, 16'h0040);
    imem[10] = encR(2, 1, 7, 6'h2A);
    imem[11] = encI(6'h2B, 0, 7, 16'h0040);
    imem[12] = encR(1, 2, 8, 6'h2A);
    imem[13] = encI(6'h2B, 0, 8, 16'h0040);
    imem[14] = encI(6'h23, 0, 9, 16'h000C);
    imem[15] = encI(6'h23, 0, 10, 16'h0010);
    imem[16] = encR(9, 10, 11, 6'h20);
    imem[17] = encI(6'h2B, 0, 11, 16'h0040);
    imem[18] = encR(11, 9, 12, 6'h2A);
    imem[19] = encI(6'h2B, 0, 12, 16'h0040);
    doReset();
    check("R5 load strobe", {31'd0, dmemRe}, 32'd1);
    check("R5 load addr", dmemAddr, 32'h0);
    step(3);
    expectStore("R3 add", 32'h40, 32'd2);
    step(2);
    expectStore("R3 sub", 32'h40, 32'd8);
    step(2);
    expectStore("R3 and", 32'h40, 32'd5);
    step(2);
    expectStore("R3 or", 32'h40, 32'hFFFF_FFFD);
    step(2);
    expectStore("R4 slt negative vs positive", 32'h40, 32'd1);
    step(2);
    expectStore("R4 slt positive vs negative", 32'h40, 32'd0);
    step(4);
    expectStore("R3 add wraps", 32'h40, 32'h8000_0000);
    step(2);
    expectStore("R4 slt signed after wrap", 32'h40, 32'd1);
    step();
    check("R2 straight-line pc", imemAddr, 32'd80);
  endtask

  task automatic testMem();
    clearMem();
    dmem[2]  = 32'h1111_2222;
    dmem[5]  = 32'h0000_0100;
    dmem[63] = 32'hCAFE_0001;
    imem[0]  = encI(6'h23, 0, 13, 16'h0014);
    imem[1]  = encI(6'h23, 0, 1, 16'h0008);
    imem[2]  = encI(6'h23, 0, 15, 16'h0014);
    imem[3]  = encI(6'h2B, 13, 1, 16'hFFF8);
    imem[4]  = encI(6'h23, 13, 14, 16'hFFFC);
    imem[5]  = encI(6'h2B, 0, 14, 16'h0050);
    imem[6]  = encR(1, 1, 0, 6'h20);
    imem[7]  = encI(6'h2B, 0, 0, 16'h0044);
    imem[8]  = encI(6'h23, 0, 0, 16'h0008);
    imem[9]  = encI(6'h2B, 0, 0, 16'h0048);
    imem[10] = encI(6'h2B, 0, 1, 16'h7800);
    imem[11] = encI(6'h2B, 0, 15, 16'h004C);
    doReset();
    check("R5 load addr with offset", dmemAddr, 32'h14);
    step(3);
    expectStore("R6 negative offset", 32'hF8, 32'h1111_2222);
    check("R10 store has no read strobe", {31'd0, dmemRe}, 32'd0);
    step();
    check("R5 load negative offset addr", dmemAddr, 32'hFC);
    step();
    expectStore("R5 load wrote rt", 32'h50, 32'hCAFE_0001);
    step(2);
    expectStore("R9 r-type write to r0 dropped", 32'h44, 32'h0);
    step(2);
    expectStore("R9 load to r0 dropped", 32'h48, 32'h0);
    step();
    expectStore("R6 store with rd bits set", 32'h7800, 32'h1111_2222);
    step();
    expectStore("R6 store wrote no register", 32'h4C, 32'h0000_0100);
  endtask

  task automatic testBranch();
    clearMem();
    dmem[0] = 32'd7;
    dmem[1] = 32'd9;
    imem[0]  = encI(6'h23, 0, 1, 16'h0000);
    imem[1]  = encI(6'h23, 0, 2, 16'h0000);
    imem[2]  = encI(6'h23, 0, 3, 16'h0004);
    imem[3]  = encI(6'h04, 1, 2, 16'h0003);
    imem[7]  = encI(6'h04, 1, 3, 16'h0005);
    imem[8]  = encI(6'h04, 0, 0, 16'h0002);
    imem[9]  = encJ(26'h10);
    imem[11] = encI(6'h04, 0, 0, 16'hFFFD);
    imem[16] = encJ(26'h3);
    doReset();
    step(3);
    check("R10 branch has no strobes", {30'd0, dmemWe, dmemRe}, 32'd0);
    step();
    check("R7 taken forward", imemAddr, 32'd28);
    step();
    check("R7 not taken", imemAddr, 32'd32);
    step();
    check("R7 taken on r0", imemAddr, 32'd44);
    step();
    check("R7 taken backward", imemAddr, 32'd36);
    step();
    check("R8 jump forward", imemAddr, 32'h40);
    step();
    check("R8 jump backward", imemAddr, 32'd12);
  endtask

  task automatic testUnsupported();
    clearMem();
    dmem[0] = 32'h0000_55AA;
    imem[0] = encI(6'h23, 0, 1, 16'h0000);
    imem[1] = encI(6'h08, 0, 1, 16'h1234);
    imem[2] = encR(1, 1, 1, 6'h00);
    imem[3] = encR(1, 1, 1, 6'h27);
    imem[4] = encI(6'h2B, 0, 1, 16'h0040);
    doReset();
    step();
    check("R10 unlisted opcode no strobes", {30'd0, dmemWe, dmemRe}, 32'd0);
    step();
    check("R10 unlisted opcode advances pc", imemAddr, 32'd8);
    step(2);
    check("R10 pc after unlisted funct", imemAddr, 32'd16);
    expectStore("R10 register untouched", 32'h40, 32'h0000_55AA);
  endtask

  initial begin
    testReset();
    testArith();
    testMem();
    testBranch();
    testUnsupported();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule